// File: doc/BRIEF.md
# Raster-Scan Provisional Component Labeler with Seed Overlap

This block runs the first raster pass of connected-component labeling on a binary image. It uses 8-connectivity. Pixels arrive one per accepted cycle in row-major order. Alongside each image pixel comes the pixel at the same position of a second binary image, the seed. Each foreground pixel gets a provisional label. The label is copied from an already labelled causal neighbour when one exists; otherwise a fresh number is handed out.

The block keeps no equivalence table. For every pixel it emits a record holding:
- the pixel's own label;
- the labels of its four causal neighbours;
- a flag that marks overlap between the foreground and the seed.

A later stage can use these records to merge equivalent labels and to keep only the components that touch the seed.

After the last pixel of a frame, the block reports how many labels the frame used and whether the label space ran out. Frame geometry and label width are parameters. The default label width is 17 bits, which covers the worst-case component count of a 504x804 frame.

Top module: `ccl_first_pass`

## Requirements
- R1: A background pixel (inFg = 0) is given label 0.
- R2: A foreground pixel takes the label of the first non-zero neighbour in the priority order left, up, upper-left, upper-right.
- R3: When all four neighbour labels of a foreground pixel are 0, the pixel gets a fresh label. Fresh labels are handed out one by one, starting at 1 in each frame, so each one is the previous count plus one.
- R4: A neighbour that lies outside the frame reads as label 0. This applies to all upper neighbours in the first row, to the left and upper-left neighbours in column 0, and to the upper-right neighbour in the last column.
- R5: Each record carries, in recLeft, recUp, recUpLeft and recUpRight, the labels the block gave earlier to the pixels at those positions. This holds for background pixels too.
- R6: recSeed is 1 exactly when the pixel is foreground and its seed bit is 1.
- R7: A record is presented (recValid = 1) in the cycle after its pixel is accepted (inValid = 1). Cycles with inValid = 0 advance nothing and produce no record.
- R8: frameDone pulses together with the record of the frame's last pixel. At that point labelTotal shows the number of labels handed out in the frame and holds that value until the next frame ends.
- R9: If a fresh label is needed while the count already equals the largest value the label width can hold, the pixel gets that largest value and the count stays there. The overflow output is then set at frame end.
- R10: The label count and the overflow condition restart at the first pixel of every frame. After an overflow frame, overflow reads 0 at the end of the next frame if no overflow happens there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A pixel pair is presented this cycle |
| inFg | input | 1 | Image pixel, 1 = foreground |
| inSeed | input | 1 | Seed image pixel at the same position |
| recValid | output | 1 | Record valid |
| recLabel | output | LABEL_W | Provisional label of the pixel |
| recLeft | output | LABEL_W | Label of the left neighbour |
| recUp | output | LABEL_W | Label of the upper neighbour |
| recUpLeft | output | LABEL_W | Label of the upper-left neighbour |
| recUpRight | output | LABEL_W | Label of the upper-right neighbour |
| recSeed | output | 1 | Foreground pixel overlaps the seed |
| frameDone | output | 1 | Pulse with the last record of a frame |
| labelTotal | output | LABEL_W | Labels handed out in the last finished frame |
| overflow | output | 1 | Label space ran out in the last finished frame |

## Verification
The assertions check, on every cycle, the relations that can be seen locally:
- an inherited label never loses to a non-zero left neighbour;
- a seed-flagged pixel always has a label;
- the count rises by at most one per pixel and never falls below a label already handed out;
- a saturated count pins the label;
- the scan position wraps after the last pixel and holds still during stalls.

Only the bench scenarios can show that neighbour labels match what was assigned a row earlier, that the frame edges read as zero, and that the end-of-frame count and the overflow restart are correct. The bench shows these by comparing whole frames against a reference model.

// File: rtl/ccl_fp_pkg.sv
package ccl_fp_pkg;

  // strobes handed from the scan control to the labelling datapath
  typedef struct packed {
    logic accept;      // pixel taken this cycle
    logic leftEdge;    // column 0
    logic rightEdge;   // last column
    logic topRow;      // row 0
    logic frameFirst;  // first pixel of a frame
    logic frameLast;   // last pixel of a frame
  } scan_strobe_t;

  localparam int NB_COUNT = 4;  // causal neighbours per pixel

endpackage

// File: rtl/ccl_fp_ctrl.sv
module ccl_fp_ctrl
  import ccl_fp_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output scan_strobe_t     strobe,
  output logic [COL_W-1:0] colIdx
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;

  always_comb begin
    strobe.accept     = inValid;
    strobe.leftEdge   = (colCnt == '0);
    strobe.rightEdge  = (colCnt == LAST_COL);
    strobe.topRow     = (rowCnt == '0);
    strobe.frameFirst = (colCnt == '0) && (rowCnt == '0);
    strobe.frameLast  = (colCnt == LAST_COL) && (rowCnt == LAST_ROW);
    colIdx            = colCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (inValid) begin
      if (colCnt == LAST_COL) begin
        colCnt <= '0;
        rowCnt <= (rowCnt == LAST_ROW) ? '0 : rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  // scan position returns to the origin after the last pixel of a frame
  assert_scan_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.frameLast) |=> (colCnt == '0 && rowCnt == '0));

  // a stalled cycle leaves the scan position untouched
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(colCnt) && $stable(rowCnt)));

endmodule

// File: rtl/ccl_fp_datapath.sv
module ccl_fp_datapath
  import ccl_fp_pkg::*;
#(
  parameter int IMG_W   = 64,
  parameter int LABEL_W = 17,
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  scan_strobe_t       strobe,
  input  logic [COL_W-1:0]   colIdx,
  input  logic               inFg,
  input  logic               inSeed,
  output logic               recValid,
  output logic [LABEL_W-1:0] recLabel,
  output logic [LABEL_W-1:0] recLeft,
  output logic [LABEL_W-1:0] recUp,
  output logic [LABEL_W-1:0] recUpLeft,
  output logic [LABEL_W-1:0] recUpRight,
  output logic               recSeed,
  output logic               frameDone,
  output logic [LABEL_W-1:0] labelTotal,
  output logic               overflow
);

  localparam logic [LABEL_W-1:0] MAX_LABEL = '1;

  // labels of the row above, overwritten column by column with this row
  logic [LABEL_W-1:0] rowBuf [IMG_W];
  logic [LABEL_W-1:0] leftReg;
  logic [LABEL_W-1:0] upLeftReg;
  logic [LABEL_W-1:0] cntReg;
  logic               ovfReg;

  logic [COL_W-1:0]   upRightIdx;
  logic [LABEL_W-1:0] rdUp;
  logic [LABEL_W-1:0] rdUpRight;
  logic [LABEL_W-1:0] nb [NB_COUNT];  // index 0 = highest priority
  logic [LABEL_W-1:0] pick;
  logic [LABEL_W-1:0] cntBase;
  logic [LABEL_W-1:0] cntNext;
  logic [LABEL_W-1:0] newLabel;
  logic               ovfBase;
  logic               ovfNext;

  always_comb begin
    upRightIdx = strobe.rightEdge ? colIdx : colIdx + 1'b1;
    rdUp       = rowBuf[colIdx];
    rdUpRight  = rowBuf[upRightIdx];
    nb[0] = strobe.leftEdge                     ? '0 : leftReg;
    nb[1] = strobe.topRow                       ? '0 : rdUp;
    nb[2] = (strobe.topRow || strobe.leftEdge)  ? '0 : upLeftReg;
    nb[3] = (strobe.topRow || strobe.rightEdge) ? '0 : rdUpRight;
  end

  // priority pick: scan from lowest to highest priority so the first wins
  always_comb begin
    pick = '0;
    for (int i = NB_COUNT - 1; i >= 0; i--) begin
      if (nb[i] != '0) pick = nb[i];
    end
  end

  always_comb begin
    cntBase  = strobe.frameFirst ? '0 : cntReg;
    ovfBase  = strobe.frameFirst ? 1'b0 : ovfReg;
    cntNext  = cntBase;
    ovfNext  = ovfBase;
    newLabel = '0;
    if (inFg) begin
      if (pick != '0) begin
        newLabel = pick;
      end else if (cntBase == MAX_LABEL) begin
        newLabel = MAX_LABEL;
        ovfNext  = 1'b1;
      end else begin
        cntNext  = cntBase + 1'b1;
        newLabel = cntNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) rowBuf[colIdx] <= newLabel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftReg    <= '0;
      upLeftReg  <= '0;
      cntReg     <= '0;
      ovfReg     <= 1'b0;
      recValid   <= 1'b0;
      recLabel   <= '0;
      recLeft    <= '0;
      recUp      <= '0;
      recUpLeft  <= '0;
      recUpRight <= '0;
      recSeed    <= 1'b0;
      frameDone  <= 1'b0;
      labelTotal <= '0;
      overflow   <= 1'b0;
    end else begin
      recValid  <= strobe.accept;
      frameDone <= strobe.accept && strobe.frameLast;
      if (strobe.accept) begin
        leftReg    <= newLabel;
        upLeftReg  <= rdUp;
        cntReg     <= cntNext;
        ovfReg     <= ovfNext;
        recLabel   <= newLabel;
        recLeft    <= nb[0];
        recUp      <= nb[1];
        recUpLeft  <= nb[2];
        recUpRight <= nb[3];
        recSeed    <= inFg && inSeed;
        if (strobe.frameLast) begin
          labelTotal <= cntNext;
          overflow   <= ovfNext;
        end
      end
    end
  end

  // a non-zero left neighbour always wins when the pixel is labelled
  assert_left_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recLabel != '0 && recLeft != '0) |-> (recLabel == recLeft));

  // a seed overlap implies a foreground pixel, which always has a label
  assert_seed_labelled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recSeed) |-> (recLabel != '0));

  // no emitted label exceeds the number handed out so far
  assert_label_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (recLabel <= cntReg));

  // within a frame the count grows by at most one per pixel
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && !strobe.frameFirst) |=>
      (cntReg == $past(cntReg) || cntReg == $past(cntReg) + 1'b1));

  // frame end coincides with a record
  assert_done_with_rec_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> recValid);

  // an overflow can only exist once the count is saturated
  assert_ovf_saturated_R9: assert property (@(posedge clk) disable iff (!rstN)
    ovfReg |-> (cntReg == MAX_LABEL));

endmodule

// File: rtl/ccl_first_pass.sv
module ccl_first_pass
  import ccl_fp_pkg::*;
#(
  parameter int IMG_W   = 64,
  parameter int IMG_H   = 48,
  parameter int LABEL_W = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inFg,
  input  logic               inSeed,
  output logic               recValid,
  output logic [LABEL_W-1:0] recLabel,
  output logic [LABEL_W-1:0] recLeft,
  output logic [LABEL_W-1:0] recUp,
  output logic [LABEL_W-1:0] recUpLeft,
  output logic [LABEL_W-1:0] recUpRight,
  output logic               recSeed,
  output logic               frameDone,
  output logic [LABEL_W-1:0] labelTotal,
  output logic               overflow
);

  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  scan_strobe_t     strobe;
  logic [COL_W-1:0] colIdx;

  ccl_fp_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .colIdx  (colIdx)
  );

  ccl_fp_datapath #(.IMG_W(IMG_W), .LABEL_W(LABEL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .colIdx     (colIdx),
    .inFg       (inFg),
    .inSeed     (inSeed),
    .recValid   (recValid),
    .recLabel   (recLabel),
    .recLeft    (recLeft),
    .recUp      (recUp),
    .recUpLeft  (recUpLeft),
    .recUpRight (recUpRight),
    .recSeed    (recSeed),
    .frameDone  (frameDone),
    .labelTotal (labelTotal),
    .overflow   (overflow)
  );

endmodule

// File: tb/ccl_first_pass_bench.sv
`timescale 1ns/1ps
module ccl_first_pass_bench;

  localparam int W    = 20;
  localparam int H    = 16;
  localparam int LW   = 6;
  localparam int NPIX = W * H;
  localparam int MAXL = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inFg = 1'b0;
  logic inSeed = 1'b0;
  logic recValid, recSeed, frameDone, overflow;
  logic [LW-1:0] recLabel, recLeft, recUp, recUpLeft, recUpRight, labelTotal;

  always #5 clk = ~clk;

  ccl_first_pass #(.IMG_W(W), .IMG_H(H), .LABEL_W(LW)) u_ccl_first_pass (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFg(inFg), .inSeed(inSeed),
    .recValid(recValid), .recLabel(recLabel), .recLeft(recLeft), .recUp(recUp),
    .recUpLeft(recUpLeft), .recUpRight(recUpRight), .recSeed(recSeed),
    .frameDone(frameDone), .labelTotal(labelTotal), .overflow(overflow)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int fgImg [NPIX];
  int sdImg [NPIX];
  int eLab [NPIX];
  int eL [NPIX];
  int eU [NPIX];
  int eUL [NPIX];
  int eUR [NPIX];
  int eKind [NPIX];  // 0 background, 1 inherited, 2 fresh, 3 saturated
  int eTotal;
  int eOvf;

  int recIdx = 0;
  bit monOn = 0;
  bit prevValid = 0;
  bit fgSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbAt(int x, int y);
    if (x < 0 || x >= W || y < 0) return 0;
    return eLab[y*W + x];
  endfunction

  task automatic buildFrame(input int kind);
    int cnt;
    cnt = 0;
    eOvf = 0;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        int p;
        p = y*W + x;
        case (kind)
          0: fgImg[p] = 0;
          1: fgImg[p] = (x % 2 == 0 && y % 2 == 0) ? 1 : 0;
          2: fgImg[p] = 1;
          3: fgImg[p] = ($urandom % 100 < 40) ? 1 : 0;
          4: fgImg[p] = ($urandom % 100 < 65) ? 1 : 0;
          5: fgImg[p] = ((x + y) % 3 == 0) ? 1 : 0;
          6: fgImg[p] = ((x - y + 60) % 3 == 0) ? 1 : 0;
          default: fgImg[p] = ($urandom % 100 < 15) ? 1 : 0;
        endcase
        sdImg[p] = (kind == 2) ? (x % 5 == 0 ? 1 : 0) : int'($urandom % 2);
      end
    end
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        int p, pk;
        p = y*W + x;
        eL[p]  = nbAt(x-1, y);
        eU[p]  = nbAt(x, y-1);
        eUL[p] = nbAt(x-1, y-1);
        eUR[p] = nbAt(x+1, y-1);
        pk = (eL[p] != 0) ? eL[p] : (eU[p] != 0) ? eU[p] :
             (eUL[p] != 0) ? eUL[p] : eUR[p];
        if (fgImg[p] == 0) begin
          eLab[p] = 0; eKind[p] = 0;
        end else if (pk != 0) begin
          eLab[p] = pk; eKind[p] = 1;
        end else if (cnt == MAXL) begin
          eLab[p] = MAXL; eKind[p] = 3; eOvf = 1;
        end else begin
          cnt++; eLab[p] = cnt; eKind[p] = 2;
        end
      end
    end
    eTotal = cnt;
  endtask

  task automatic sendFrame();
    recIdx = 0;
    fgSeen = 0;
    for (int p = 0; p < NPIX; p++) begin
      while ($urandom % 4 == 0) begin
        @(posedge clk); #2;
        inValid = 1'b0; inFg = 1'($urandom % 2); inSeed = 1'($urandom % 2);
      end
      @(posedge clk); #2;
      inValid = 1'b1; inFg = 1'(fgImg[p]); inSeed = 1'(sdImg[p]);
    end
    @(posedge clk); #2;
    inValid = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk(recIdx == NPIX, "R7", "records per frame", recIdx, NPIX);
  endtask

  // record checker, sampled away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      chk(recValid == prevValid, "R7", "record follows accepted pixel",
          int'(recValid), int'(prevValid));
      if (recValid && recIdx < NPIX) begin
        int p, x, y;
        string lr, nr;
        p = recIdx; x = p % W; y = p / W;
        case (eKind[p])
          0: lr = "R1";
          1: lr = "R2";
          2: lr = "R3";
          default: lr = "R9";
        endcase
        chk(int'(recLabel) == eLab[p], lr, "label", int'(recLabel), eLab[p]);
        if (eLab[p] != 0 && !fgSeen) begin
          fgSeen = 1;
          chk(int'(recLabel) == 1, "R10", "first label of frame", int'(recLabel), 1);
        end
        nr = (x == 0 || x == W-1 || y == 0) ? "R4" : "R5";
        chk(int'(recLeft) == eL[p], nr, "left label", int'(recLeft), eL[p]);
        chk(int'(recUp) == eU[p], nr, "up label", int'(recUp), eU[p]);
        chk(int'(recUpLeft) == eUL[p], nr, "up-left label", int'(recUpLeft), eUL[p]);
        chk(int'(recUpRight) == eUR[p], nr, "up-right label", int'(recUpRight), eUR[p]);
        chk(int'(recSeed) == (fgImg[p] & sdImg[p]), "R6", "seed flag",
            int'(recSeed), fgImg[p] & sdImg[p]);
        if (p == NPIX - 1) begin
          chk(frameDone == 1'b1, "R8", "frame end pulse", int'(frameDone), 1);
          chk(int'(labelTotal) == eTotal, "R8", "label total", int'(labelTotal), eTotal);
          chk(int'(overflow) == eOvf, "R9", "overflow flag", int'(overflow), eOvf);
        end else begin
          chk(frameDone == 1'b0, "R8", "no early frame end", int'(frameDone), 0);
        end
        recIdx++;
      end
      prevValid = inValid;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(recValid == 1'b0, "R7", "reset record valid", int'(recValid), 0);
    chk(frameDone == 1'b0, "R8", "reset frame end", int'(frameDone), 0);
    chk(int'(labelTotal) == 0, "R8", "reset label total", int'(labelTotal), 0);
    chk(overflow == 1'b0, "R9", "reset overflow", int'(overflow), 0);
    monOn = 1;
    // all background, dot grid that overflows, solid frame after overflow (R10),
    // random densities, diagonal chains that rely on upper-right / upper-left
    for (int k = 0; k < 9; k++) begin
      buildFrame(k);
      sendFrame();
    end
    @(negedge clk);
    chk(int'(overflow) == eOvf, "R8", "result held after frame", int'(overflow), eOvf);
    chk(int'(labelTotal) == eTotal, "R8", "total held after frame", int'(labelTotal), eTotal);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule